// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Core with Frozen Host Copy

This block keeps time as packed BCD fields. The fields are hundredths of a second, seconds, minutes, hours, weekday, day of month, month and year. Each pulse on a 100 Hz tick input advances the internal copy of the fields. A second, host-visible copy is loaded from the internal copy in one cycle. That load is suspended while the host is reading a time field or while the halt-update flag is set. When the suspension ends, all eight fields move across together. The internal counters keep running during the suspension, so the host always reads a coherent snapshot and no time is lost.

The host reaches the block through a flat register port: one address bus, a write strobe, and a level that marks an active read burst. The read data is combinational from the host copy at the current address. A write to a time field updates both copies in the same cycle and clears the hundredths field. A power-fail input latches the halt-update flag, so the host copy keeps the time at which the failure happened until software clears the flag. An 8-bit control byte is kept as plain storage. Calibration, alarm and watchdog logic are not part of the block.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, addresses 0h–7h read 00,00,00,00,01,01,01,00, the control byte at 8h reads 00, and the flag byte at Ch reads 00.
- R2: Each tick adds one to the hundredths field (BCD 00–99). A carry goes on to seconds (00–59), then minutes (00–59), then hours in 24-hour form (00–23). The host copy shows the result one cycle after the internal copy changes.
- R3: When hours roll over, the weekday (address 4h, bits 2:0, 1–7) and the day of month (5h) advance. The day of month wraps to 01 after 31, or after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 28, or after 29 when the BCD year (7h) is divisible by 4. Month (6h) wraps from 12 to 01, and year from 99 to 00.
- R4: At address 3h, bit 7 is the century enable and bit 6 is the century flag. Bits 5:0 hold the hour. The flag inverts when the year wraps from 99 to 00 and the enable is 1. When the enable is 0, the flag keeps its value.
- R5: While bit 7 of address 1h is 1, no field counts and ticks are ignored. Clearing the bit lets counting resume from the held value.
- R6: A write to address 0h–7h stores the byte in both copies and forces hundredths to 00 in both copies. The byte is masked to bits 2:0 at 4h, bits 5:0 at 5h and bits 4:0 at 6h. Write data at 0h is ignored. A tick in the same cycle as such a write is discarded.
- R7: While the read-active input is high and the address is 0h–7h, the host copy holds its value. It is loaded from the internal copy on the first clock after the read-active input drops or the address moves to 8h or above.
- R8: The power-fail input sets bit 6 of address Ch, and the host copy then holds its value. Writing Ch with bit 6 at 0 clears the flag. Writing it with bit 6 at 1 leaves the flag unchanged. The other bits of Ch read 0.
- R9: Address 8h is 8-bit read/write storage with no effect on timekeeping. Addresses 9h–Bh and Dh–Fh ignore writes and read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz that advances the time |
| pwr_fail | input | 1 | Power-failure indication; sets the halt-update flag |
| reg_wr | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| rd_active | input | 1 | High while the host has a read burst open |
| reg_rdata | output | 8 | Read data from the host copy at reg_addr |

## Verification
The hardest case to reach from the ports is the host copy staying put while the internal counters move well ahead. That happens during a long read burst, during a halt-update window, or when the read pointer leaves the time fields and comes back. The bench holds read-active on a time address for hundreds of ticks and confirms the old value is still visible. It then drops the burst and checks the new hundredths and seconds together. In a separate step it parks the pointer at 9h in the middle of a burst and returns it to 0h, which shows the copy resumed while the pointer was away. Calendar corners are reached by writing the date fields and then the time 23:59:59, so that exactly 100 ticks cross midnight.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 8;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int IW     = $clog2(NFIELD);

  localparam int F_HUND  = 0;
  localparam int F_SEC   = 1;
  localparam int F_MIN   = 2;
  localparam int F_HOUR  = 3;
  localparam int F_WDAY  = 4;
  localparam int F_MDAY  = 5;
  localparam int F_MONTH = 6;
  localparam int F_YEAR  = 7;

  localparam logic [AW-1:0] A_CTRL = 4'h8;
  localparam logic [AW-1:0] A_FLAG = 4'hC;

  localparam int STOP_BIT = 7;
  localparam int CEN_BIT  = 7;
  localparam int CFL_BIT  = 6;
  localparam int HALT_BIT = 6;

  typedef logic [NFIELD-1:0][DW-1:0] bank_t;

  // bits of each field that take part in counting
  function automatic logic [DW-1:0] val_mask(input int i);
    case (i)
      F_SEC, F_MIN: val_mask = 8'h7F;
      F_HOUR:       val_mask = 8'h3F;
      F_WDAY:       val_mask = 8'h07;
      F_MDAY:       val_mask = 8'h3F;
      F_MONTH:      val_mask = 8'h1F;
      default:      val_mask = 8'hFF;
    endcase
  endfunction

  // bits of each field a host write may set
  function automatic logic [DW-1:0] wr_mask(input int i);
    case (i)
      F_WDAY:  wr_mask = 8'h07;
      F_MDAY:  wr_mask = 8'h3F;
      F_MONTH: wr_mask = 8'h1F;
      default: wr_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] lo_lim(input int i);
    case (i)
      F_WDAY, F_MDAY, F_MONTH: lo_lim = 8'h01;
      default:                 lo_lim = 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] hi_lim(input int i);
    case (i)
      F_SEC, F_MIN: hi_lim = 8'h59;
      F_HOUR:       hi_lim = 8'h23;
      F_WDAY:       hi_lim = 8'h07;
      F_MDAY:       hi_lim = 8'h31;
      F_MONTH:      hi_lim = 8'h12;
      default:      hi_lim = 8'h99;
    endcase
  endfunction

  // which field's carry advances field i (weekday and day share the hour carry)
  function automatic int carry_src(input int i);
    case (i)
      F_WDAY:  carry_src = F_HOUR;
      F_MDAY:  carry_src = F_HOUR;
      F_MONTH: carry_src = F_MDAY;
      default: carry_src = i - 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] rst_val(input int i);
    rst_val = lo_lim(i);
  endfunction

  function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
(
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic          en,
  output logic [DW-1:0] nxt,
  output logic          cout
);
  logic at_top;

  always_comb begin
    at_top = (cur == hi);
    cout   = en && at_top;
    if (!en)        nxt = cur;
    else if (at_top) nxt = lo;
    else            nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [DW-1:0] month,
  input  logic [DW-1:0] year,
  output logic [DW-1:0] last_day
);
  logic [4:0] mod_sum;
  logic       leap;

  always_comb begin
    // (10*tens + ones) mod 4 == (2*tens + ones) mod 4
    mod_sum = {year[7:4], 1'b0} + {1'b0, year[3:0]};
    leap    = (mod_sum[1:0] == 2'b00);
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output bank_t         bank_q
);
  bank_t              bank_d;
  bank_t              cur_v;
  bank_t              nxt_v;
  bank_t              hi_v;
  logic [NFIELD-1:0]  cin;
  logic [NFIELD-1:0]  cout;
  logic [DW-1:0]      mday_last;
  logic               stopped;
  logic               step;
  logic               load;

  assign stopped = bank_q[F_SEC][STOP_BIT];
  assign step    = tick && !stopped && !wr_en;
  assign load    = wr_en || step;

  rtc_month_len u_mlen (
    .month   (cur_v[F_MONTH]),
    .year    (cur_v[F_YEAR]),
    .last_day(mday_last)
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign cur_v[i] = bank_q[i] & val_mask(i);
    if (i == F_MDAY) begin : g_hi_dyn
      assign hi_v[i] = mday_last;
    end else begin : g_hi_fix
      assign hi_v[i] = hi_lim(i);
    end
    if (i == 0) begin : g_cin_tick
      assign cin[i] = step;
    end else begin : g_cin_chain
      assign cin[i] = cout[carry_src(i)];
    end
    rtc_bcd_field u_fld (
      .cur (cur_v[i]),
      .lo  (lo_lim(i)),
      .hi  (hi_v[i]),
      .en  (cin[i]),
      .nxt (nxt_v[i]),
      .cout(cout[i])
    );
  end

  always_comb begin
    bank_d = bank_q;
    if (wr_en) begin
      bank_d[wr_idx] = wr_data & wr_mask(int'(wr_idx));
      bank_d[F_HUND] = '0;
    end else if (step) begin
      for (int i = 0; i < NFIELD; i++)
        bank_d[i] = (bank_q[i] & ~val_mask(i)) | nxt_v[i];
      if (cout[F_YEAR] && bank_q[F_HOUR][CEN_BIT])
        bank_d[F_HOUR][CFL_BIT] = ~bank_q[F_HOUR][CFL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) bank_q[i] <= rst_val(i);
    end else if (load) begin
      bank_q <= bank_d;
    end
  end

  // R5: stop bit freezes every internal field
  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wr_en) |=> $stable(bank_q));
  // R6: any clock write leaves hundredths at zero
  a_r6_wr_zero_hund: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_q[F_HUND] == '0));
  // R4: century flag is locked while enable is clear
  a_r4_cfl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_q[F_HOUR][CEN_BIT] && !wr_en) |=> $stable(bank_q[F_HOUR][CFL_BIT]));
  // R2: hundredths always holds legal BCD digits
  a_r2_hund_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q[F_HUND][3:0] <= 4'd9) && (bank_q[F_HUND][7:4] <= 4'd9));
endmodule

// File: rtl/rtc_user_shadow.sv
module rtc_user_shadow
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  bank_t         bank_i,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_active,
  input  logic          pwr_fail,
  output logic [DW-1:0] rd_data
);
  bank_t          user_q, user_d;
  logic [DW-1:0]  ctrl_q;
  logic           halt_q, halt_d;
  logic           tk_addr;
  logic           tk_wr;
  logic           freeze;
  logic           user_en;
  logic           ctrl_en;

  assign tk_addr = (int'(addr) < NFIELD);
  assign tk_wr   = wr_en && tk_addr;
  assign freeze  = (rd_active && tk_addr) || halt_q;
  assign user_en = tk_wr || !freeze;
  assign ctrl_en = wr_en && (addr == A_CTRL);

  always_comb begin
    user_d = user_q;
    if (tk_wr) begin
      user_d[addr[IW-1:0]] = wr_data & wr_mask(int'(addr[IW-1:0]));
      user_d[F_HUND]       = '0;
    end else begin
      user_d = bank_i;
    end
  end

  always_comb begin
    halt_d = halt_q;
    if (pwr_fail)
      halt_d = 1'b1;
    else if (wr_en && (addr == A_FLAG) && !wr_data[HALT_BIT])
      halt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) user_q[i] <= rst_val(i);
    end else if (user_en) begin
      user_q <= user_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  // R9: only 8h and Ch are mapped beyond the time fields
  always_comb begin
    rd_data = '0;
    if (tk_addr)              rd_data = user_q[addr[IW-1:0]];
    else if (addr == A_CTRL)  rd_data = ctrl_q;
    else if (addr == A_FLAG)  rd_data[HALT_BIT] = halt_q;
  end

  // R7: host copy holds during a read burst on a time address
  a_r7_read_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && tk_addr && !wr_en) |=> $stable(user_q));
  // R7: with no freeze source the copy follows the internal bank
  a_r7_resume_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_active && !halt_q && !wr_en) |=> (user_q == $past(bank_i)));
  // R8: power fail latches the halt flag
  a_r8_pwrfail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> halt_q);
  // R8: halt flag blocks the copy
  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> $stable(user_q));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_100hz,
  input  logic          pwr_fail,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          rd_active,
  output logic [DW-1:0] reg_rdata
);
  logic [1:0] rst_pipe;
  logic       core_rst_n;
  logic       tk_wr;
  bank_t      bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign tk_wr = reg_wr && (int'(reg_addr) < NFIELD);

  rtc_time_counter u_cnt (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .tick   (tick_100hz),
    .wr_en  (tk_wr),
    .wr_idx (reg_addr[IW-1:0]),
    .wr_data(reg_wdata),
    .bank_q (bank)
  );

  rtc_user_shadow u_shd (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .bank_i   (bank),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wr_data  (reg_wdata),
    .rd_active(rd_active),
    .pwr_fail (pwr_fail),
    .rd_data  (reg_rdata)
  );
endmodule

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic       rd_active = 1'b0;
  logic [7:0] reg_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rtc_bcd_core u_rtc_bcd_core (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .pwr_fail(pwr_fail),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_active(rd_active), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic [3:0] wa;   // F = no write
    logic [7:0] wd;
    logic [7:0] nt;
    logic [3:0] ra;
    logic [7:0] ex;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{4'hF, 8'h00, 8'd5,   4'h0, 8'h05, 4'd2},  // R2 hundredths count
    '{4'hF, 8'h00, 8'd95,  4'h1, 8'h01, 4'd2},  // R2 carry to seconds
    '{4'hF, 8'h00, 8'd0,   4'h0, 8'h00, 4'd2},
    '{4'h1, 8'h59, 8'd100, 4'h2, 8'h01, 4'd2},  // R2 seconds to minutes
    '{4'hF, 8'h00, 8'd0,   4'h1, 8'h00, 4'd2},
    '{4'h3, 8'h23, 8'd0,   4'h3, 8'h23, 4'd6},  // R6
    '{4'h2, 8'h59, 8'd0,   4'h2, 8'h59, 4'd6},
    '{4'h1, 8'h59, 8'd100, 4'h3, 8'h00, 4'd2},  // R2 hours wrap
    '{4'hF, 8'h00, 8'd0,   4'h5, 8'h02, 4'd3},  // R3 day advances
    '{4'hF, 8'h00, 8'd0,   4'h4, 8'h02, 4'd3},  // R3 weekday advances
    '{4'h0, 8'h77, 8'd3,   4'h0, 8'h03, 4'd6},  // R6 data at 0h ignored
    '{4'h4, 8'hFF, 8'd0,   4'h4, 8'h07, 4'd6},  // R6 weekday mask
    '{4'h8, 8'hA5, 8'd0,   4'h8, 8'hA5, 4'd9},  // R9 control storage
    '{4'h9, 8'h5A, 8'd0,   4'h9, 8'h00, 4'd9},  // R9 unmapped
    '{4'h7, 8'h99, 8'd0,   4'h7, 8'h99, 4'd6}
  };

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
    end
  endtask

  task automatic sample(input logic [3:0] a, input logic [7:0] ex, input string rq);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== ex) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", rq, a, reg_rdata, ex);
    end
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] ex, input string rq);
    @(negedge clk); @(negedge clk);
    sample(a, ex, rq);
  endtask

  task automatic roll_day(input logic [7:0] hr);
    wr(4'h3, hr); wr(4'h2, 8'h59); wr(4'h1, 8'h59);
    ticks(100);
  endtask

  function automatic logic [7:0] reset_exp(input int a);
    if (a >= 4 && a <= 6) return 8'h01;
    return 8'h00;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 16; a++) sample(4'(a), reset_exp(a), "R1");

    for (int v = 0; v < NV; v++) begin
      if (VT[v].wa != 4'hF) wr(VT[v].wa, VT[v].wd);
      ticks(int'(VT[v].nt));
      chk(VT[v].ra, VT[v].ex, $sformatf("R%0d", VT[v].rq));
    end

    // R6 tick in the same cycle as a write is discarded
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 8'h05; tick_100hz = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_100hz = 1'b0;
    chk(4'h0, 8'h00, "R6");
    chk(4'h2, 8'h05, "R6");

    // R3 month lengths and leap years
    wr(4'h7, 8'h21); wr(4'h6, 8'h01); wr(4'h5, 8'h31); roll_day(8'h23);
    chk(4'h5, 8'h01, "R3"); chk(4'h6, 8'h02, "R3");
    wr(4'h6, 8'h04); wr(4'h5, 8'h30); roll_day(8'h23);
    chk(4'h5, 8'h01, "R3"); chk(4'h6, 8'h05, "R3");
    wr(4'h7, 8'h23); wr(4'h6, 8'h02); wr(4'h5, 8'h28); roll_day(8'h23);
    chk(4'h5, 8'h01, "R3"); chk(4'h6, 8'h03, "R3");
    wr(4'h7, 8'h24); wr(4'h6, 8'h02); wr(4'h5, 8'h28); roll_day(8'h23);
    chk(4'h5, 8'h29, "R3");
    roll_day(8'h23);
    chk(4'h5, 8'h01, "R3"); chk(4'h6, 8'h03, "R3");
    wr(4'h4, 8'h07); roll_day(8'h23);
    chk(4'h4, 8'h01, "R3");

    // R4 century flag
    wr(4'h7, 8'h99); wr(4'h6, 8'h12); wr(4'h5, 8'h31); roll_day(8'hA3);
    chk(4'h7, 8'h00, "R3"); chk(4'h6, 8'h01, "R3");
    chk(4'h3, 8'hC0, "R4");
    wr(4'h7, 8'h99); wr(4'h6, 8'h12); wr(4'h5, 8'h31); roll_day(8'hE3);
    chk(4'h3, 8'h80, "R4");
    wr(4'h7, 8'h99); wr(4'h6, 8'h12); wr(4'h5, 8'h31); roll_day(8'h23);
    chk(4'h3, 8'h00, "R4");

    // R5 stop bit
    wr(4'h1, 8'h80); ticks(50);
    chk(4'h0, 8'h00, "R5"); chk(4'h1, 8'h80, "R5");
    wr(4'h1, 8'h00); ticks(7);
    chk(4'h0, 8'h07, "R5");

    // R7 read freeze and single-cycle release
    wr(4'h1, 8'h10);
    @(negedge clk); rd_active = 1'b1; reg_addr = 4'h0;
    ticks(250);
    chk(4'h1, 8'h10, "R7"); chk(4'h0, 8'h00, "R7");
    @(negedge clk); rd_active = 1'b0;
    chk(4'h0, 8'h50, "R7"); chk(4'h1, 8'h12, "R7");

    // R7 pointer moving past the time fields resumes the copy
    wr(4'h1, 8'h00);
    @(negedge clk); @(negedge clk); rd_active = 1'b1; reg_addr = 4'h0;
    ticks(7);
    chk(4'h0, 8'h00, "R7");
    @(negedge clk); reg_addr = 4'h9;
    repeat (3) @(negedge clk);
    sample(4'h0, 8'h07, "R7");
    @(negedge clk); rd_active = 1'b0;

    // R8 halt-update flag
    wr(4'h1, 8'h00);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    chk(4'hC, 8'h40, "R8"); chk(4'h0, 8'h00, "R8");
    ticks(20);
    chk(4'h0, 8'h00, "R8");
    wr(4'hC, 8'h40);
    chk(4'hC, 8'h40, "R8");
    wr(4'hC, 8'h00);
    chk(4'hC, 8'h00, "R8"); chk(4'h0, 8'h20, "R8");
    chk(4'h8, 8'hA5, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule